// File: doc/BRIEF.md
# Trigger Resource Recognizer Bank

This block looks at each acquired sample word of a logic-analyzer front end and raises a set of match flags that the trigger sequencer and the storage qualifier consume. It holds four kinds of recognizer. Pattern units compare the sample bit by bit against a stored value, with a care mask that can exclude any bit. Range units report whether the sample lies between two unsigned bounds, and they report out-of-range on a separate flag. One edge unit watches for enabled rising or falling transitions between consecutive samples. One glitch unit watches a per-channel glitch indication that arrives with the sample.

All settings live in a small register file that is written and read through a plain address/data port. A scratch test register in the same file lets software prove the write and read path before it relies on the recognizers. Samples enter on a valid/ready stream, and the flags for each accepted sample leave on a one-deep valid/ready output stage. The input is accepted only when the output stage is empty or is being drained in the same cycle. While the output is held back, the flags stay frozen and the input is stalled. No sample is dropped and no sample is repeated.

Top module: `trig_resource_bank`

## Requirements
- R1: A write to the test register at address 0x00 is returned unchanged by a read of address 0x00 (combinational read data).
- R2: Each configuration register reads back the last value written to it. Pattern unit i uses value at 0x10+2i and care mask at 0x11+2i. Range unit j uses lower bound at 0x20+2j and upper bound at 0x21+2j. The rising-edge enable is at 0x30, the falling-edge enable at 0x31 and the glitch enable at 0x32. Any other address reads 0.
- R3: Pattern flag i (bit i of m_pat) is 1 when every sample bit whose care-mask bit is 1 equals the matching value bit. With a mask of 0 the flag is always 1.
- R4: In-range flag j (bit j of m_in_range) is 1 when lower ≤ sample ≤ upper, unsigned, with both ends inclusive.
- R5: Out-of-range flag j is 1 exactly when in-range flag j is 0.
- R6: The edge flag is 1 when any channel goes 0→1 with its rising-enable bit set, or 1→0 with its falling-enable bit set, comparing the sample with the previously accepted sample.
- R7: The first sample accepted after reset never raises the edge flag.
- R8: The glitch flag is 1 when s_glitch AND the glitch enable is nonzero.
- R9: The flags of a sample accepted at a clock edge appear, with m_valid high, right after that edge. m_valid falls after a drain edge when no new sample is accepted.
- R10: s_ready equals (not m_valid) or m_ready. While m_valid is high and m_ready is low, all flags hold their values.
- R11: Reset clears m_valid and every configuration register, the test register included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration register address |
| cfg_wdata | input | W | Configuration write data |
| cfg_rdata | output | W | Read data for cfg_addr |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high with s_valid |
| s_sample | input | W | Acquired sample word |
| s_glitch | input | W | Per-channel glitch indication for the sample |
| m_valid | output | 1 | Flags valid |
| m_ready | input | 1 | Downstream takes the flags |
| m_pat | output | NPAT | Pattern match flags |
| m_in_range | output | NRNG | In-range flags |
| m_out_range | output | NRNG | Out-of-range flags |
| m_edge | output | 1 | Edge recognized |
| m_glitch | output | 1 | Glitch recognized |

## Verification
The assertions check on every cycle that the in-range and out-of-range results disagree, that frozen flags stay frozen under back-pressure, that an accepted sample always produces valid output, that the first post-reset sample raises no edge, that a full-mask pattern reduces to equality, and that a test-register write is read back. The actual match values depend on the programmed settings and on sample history. Only the bench's scenarios can show them: the inclusive range ends, masked bits, edge polarity enables, glitch masking, and the readback of every register after reset.

// File: rtl/trb_pkg.sv
package trb_pkg;
  localparam int TRB_AW        = 8;
  localparam int TRB_TEST_ADDR = 'h00;
  localparam int TRB_PAT_BASE  = 'h10;
  localparam int TRB_RNG_BASE  = 'h20;
  localparam int TRB_RISE_ADDR = 'h30;
  localparam int TRB_FALL_ADDR = 'h31;
  localparam int TRB_GLT_ADDR  = 'h32;
  localparam int TRB_MAX_UNITS = 8;
endpackage

// File: rtl/trb_cfg_regs.sv
module trb_cfg_regs
  import trb_pkg::*;
#(
  parameter int W    = 16,
  parameter int AW   = TRB_AW,
  parameter int NPAT = 4,
  parameter int NRNG = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [AW-1:0]             cfg_addr,
  input  logic [W-1:0]              cfg_wdata,
  output logic [W-1:0]              cfg_rdata,
  output logic [NPAT-1:0][W-1:0]    pat_val,
  output logic [NPAT-1:0][W-1:0]    pat_mask,
  output logic [NRNG-1:0][W-1:0]    rng_lo,
  output logic [NRNG-1:0][W-1:0]    rng_hi,
  output logic [W-1:0]              rise_en,
  output logic [W-1:0]              fall_en,
  output logic [W-1:0]              glt_en
);
  localparam logic [AW-1:0] A_TEST = AW'(TRB_TEST_ADDR);
  localparam logic [AW-1:0] A_RISE = AW'(TRB_RISE_ADDR);
  localparam logic [AW-1:0] A_FALL = AW'(TRB_FALL_ADDR);
  localparam logic [AW-1:0] A_GLT  = AW'(TRB_GLT_ADDR);

  logic [W-1:0] test_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q  <= '0;
      rise_en <= '0;
      fall_en <= '0;
      glt_en  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_TEST) test_q  <= cfg_wdata;
      if (cfg_addr == A_RISE) rise_en <= cfg_wdata;
      if (cfg_addr == A_FALL) fall_en <= cfg_wdata;
      if (cfg_addr == A_GLT)  glt_en  <= cfg_wdata;
    end
  end

  for (genvar i = 0; i < NPAT; i++) begin : g_pat_regs
    localparam logic [AW-1:0] A_V = AW'(TRB_PAT_BASE + 2*i);
    localparam logic [AW-1:0] A_M = AW'(TRB_PAT_BASE + 2*i + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pat_val[i]  <= '0;
        pat_mask[i] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == A_V) pat_val[i]  <= cfg_wdata;
        if (cfg_addr == A_M) pat_mask[i] <= cfg_wdata;
      end
    end
  end

  for (genvar j = 0; j < NRNG; j++) begin : g_rng_regs
    localparam logic [AW-1:0] A_L = AW'(TRB_RNG_BASE + 2*j);
    localparam logic [AW-1:0] A_H = AW'(TRB_RNG_BASE + 2*j + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rng_lo[j] <= '0;
        rng_hi[j] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == A_L) rng_lo[j] <= cfg_wdata;
        if (cfg_addr == A_H) rng_hi[j] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_TEST) cfg_rdata = test_q;
    if (cfg_addr == A_RISE) cfg_rdata = rise_en;
    if (cfg_addr == A_FALL) cfg_rdata = fall_en;
    if (cfg_addr == A_GLT)  cfg_rdata = glt_en;
    for (int i = 0; i < NPAT; i++) begin
      if (cfg_addr == AW'(TRB_PAT_BASE + 2*i))     cfg_rdata = pat_val[i];
      if (cfg_addr == AW'(TRB_PAT_BASE + 2*i + 1)) cfg_rdata = pat_mask[i];
    end
    for (int j = 0; j < NRNG; j++) begin
      if (cfg_addr == AW'(TRB_RNG_BASE + 2*j))     cfg_rdata = rng_lo[j];
      if (cfg_addr == AW'(TRB_RNG_BASE + 2*j + 1)) cfg_rdata = rng_hi[j];
    end
  end

  AST_TESTREG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == A_TEST) |=> (cfg_addr != A_TEST) || (cfg_rdata == $past(cfg_wdata))); // R1
endmodule

// File: rtl/trb_pattern.sv
module trb_pattern #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] value,
  input  logic [W-1:0] mask,
  output logic         hit
);
  assign hit = ~|((sample ^ value) & mask);

  AST_PAT_FULLMASK_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> (hit == (sample == value))); // R3
endmodule

// File: rtl/trb_range.sv
module trb_range #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         in_hit,
  output logic         out_hit
);
  assign in_hit  = (sample >= lo) && (sample <= hi);
  assign out_hit = (sample < lo) || (sample > hi);

  AST_RANGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_hit != out_hit); // R5
endmodule

// File: rtl/trb_transition.sv
module trb_transition #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] glitch,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] glt_en,
  output logic         edge_hit,
  output logic         glitch_hit,
  output logic         prev_ok
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rose;
  logic [W-1:0] fell;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      prev_ok <= 1'b0;
    end else if (accept) begin
      prev_q  <= sample;
      prev_ok <= 1'b1;
    end
  end

  assign rose       = ~prev_q & sample;
  assign fell       = prev_q & ~sample;
  assign edge_hit   = prev_ok && (|((rose & rise_en) | (fell & fall_en)));
  assign glitch_hit = |(glitch & glt_en);

  AST_PREV_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> prev_ok); // R7
endmodule

// File: rtl/trig_resource_bank.sv
module trig_resource_bank
  import trb_pkg::*;
#(
  parameter int W    = 16,
  parameter int AW   = TRB_AW,
  parameter int NPAT = 4,
  parameter int NRNG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [W-1:0]    cfg_wdata,
  output logic [W-1:0]    cfg_rdata,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [W-1:0]    s_sample,
  input  logic [W-1:0]    s_glitch,
  output logic            m_valid,
  input  logic            m_ready,
  output logic [NPAT-1:0] m_pat,
  output logic [NRNG-1:0] m_in_range,
  output logic [NRNG-1:0] m_out_range,
  output logic            m_edge,
  output logic            m_glitch
);
  localparam int FLAG_W = NPAT + 2*NRNG + 2;

  initial begin
    if (NPAT < 1 || NPAT > TRB_MAX_UNITS) $error("NPAT out of range");
    if (NRNG < 1 || NRNG > TRB_MAX_UNITS) $error("NRNG out of range");
  end

  logic [NPAT-1:0][W-1:0] pat_val, pat_mask;
  logic [NRNG-1:0][W-1:0] rng_lo, rng_hi;
  logic [W-1:0]           rise_en, fall_en, glt_en;
  logic [NPAT-1:0]        pat_hit;
  logic [NRNG-1:0]        in_hit, out_hit;
  logic                   edge_hit, glitch_hit, prev_ok;
  logic                   accept;
  logic                   valid_q;

  assign s_ready = !valid_q || m_ready;
  assign accept  = s_valid && s_ready;
  assign m_valid = valid_q;

  trb_cfg_regs #(.W(W), .AW(AW), .NPAT(NPAT), .NRNG(NRNG)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pat_val(pat_val), .pat_mask(pat_mask), .rng_lo(rng_lo), .rng_hi(rng_hi),
    .rise_en(rise_en), .fall_en(fall_en), .glt_en(glt_en)
  );

  for (genvar i = 0; i < NPAT; i++) begin : g_pat
    trb_pattern #(.W(W)) u_pat (
      .clk(clk), .rst_n(rst_n), .sample(s_sample),
      .value(pat_val[i]), .mask(pat_mask[i]), .hit(pat_hit[i])
    );
  end

  for (genvar j = 0; j < NRNG; j++) begin : g_rng
    trb_range #(.W(W)) u_rng (
      .clk(clk), .rst_n(rst_n), .sample(s_sample),
      .lo(rng_lo[j]), .hi(rng_hi[j]), .in_hit(in_hit[j]), .out_hit(out_hit[j])
    );
  end

  trb_transition #(.W(W)) u_trans (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .sample(s_sample), .glitch(s_glitch),
    .rise_en(rise_en), .fall_en(fall_en), .glt_en(glt_en),
    .edge_hit(edge_hit), .glitch_hit(glitch_hit), .prev_ok(prev_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= 1'b0;
      m_pat       <= '0;
      m_in_range  <= '0;
      m_out_range <= '0;
      m_edge      <= 1'b0;
      m_glitch    <= 1'b0;
    end else if (accept) begin
      valid_q     <= 1'b1;
      m_pat       <= pat_hit;
      m_in_range  <= in_hit;
      m_out_range <= out_hit;
      m_edge      <= edge_hit;
      m_glitch    <= glitch_hit;
    end else if (m_ready) begin
      valid_q     <= 1'b0;
    end
  end

  logic [FLAG_W-1:0] flags_bus;
  assign flags_bus = {m_pat, m_in_range, m_out_range, m_edge, m_glitch};

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(flags_bus))); // R10
  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid); // R9
  AST_FIRST_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !prev_ok) |=> !m_edge); // R7
  AST_RANGE_FLAGS_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ((m_in_range & m_out_range) == '0)); // R5
endmodule

// File: tb/sim_trig_resource_bank.sv
module sim_trig_resource_bank;
  localparam int W = 16, AW = 8, NPAT = 4, NRNG = 2;
  localparam int NV = 10;
  // entry: {sample, glitch, pat[3:0], in_range[1:0], edge, glitch_flag}
  localparam logic [39:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 4'b0100, 2'b00, 1'b0, 1'b0},
    {16'h0001, 16'h0100, 4'b0100, 2'b00, 1'b1, 1'b1},
    {16'h0010, 16'h0200, 4'b0100, 2'b01, 1'b0, 1'b0},
    {16'h0012, 16'h0000, 4'b0100, 2'b01, 1'b0, 1'b0},
    {16'h0020, 16'h0000, 4'b0100, 2'b01, 1'b1, 1'b0},
    {16'h0021, 16'h0000, 4'b0100, 2'b00, 1'b1, 1'b0},
    {16'h1234, 16'h0000, 4'b0101, 2'b10, 1'b0, 1'b0},
    {16'h80A5, 16'h0101, 4'b1110, 2'b00, 1'b1, 1'b1},
    {16'hFFFF, 16'h0000, 4'b1100, 2'b00, 1'b0, 1'b0},
    {16'hFFFC, 16'h0000, 4'b1100, 2'b00, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0, cfg_rdata;
  logic s_valid = 0, s_ready, m_valid, m_ready = 1;
  logic [W-1:0] s_sample = '0, s_glitch = '0;
  logic [NPAT-1:0] m_pat;
  logic [NRNG-1:0] m_in_range, m_out_range;
  logic m_edge, m_glitch;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  trig_resource_bank #(.W(W), .AW(AW), .NPAT(NPAT), .NRNG(NRNG)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .s_glitch(s_glitch), .m_valid(m_valid), .m_ready(m_ready),
    .m_pat(m_pat), .m_in_range(m_in_range), .m_out_range(m_out_range),
    .m_edge(m_edge), .m_glitch(m_glitch)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [W-1:0] exp, input string req);
    @(negedge clk); cfg_addr = a; #1;
    chk(cfg_rdata == exp, req, "readback", cfg_rdata, exp);
  endtask

  task automatic send(input logic [W-1:0] s, input logic [W-1:0] g);
    @(negedge clk); s_valid = 1; s_sample = s; s_glitch = g;
    @(negedge clk); s_valid = 0; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(m_valid == 0, "R11", "m_valid in reset", m_valid, 0);
    rst_n = 1;
    rd_chk(8'h00, 16'h0000, "R11");
    chk(s_ready == 1, "R10", "s_ready idle", s_ready, 1);
    // R1 test register
    wr(8'h00, 16'hA5C3);
    rd_chk(8'h00, 16'hA5C3, "R1");
    wr(8'h00, 16'h5A3C);
    rd_chk(8'h00, 16'h5A3C, "R1");
    // configuration
    wr(8'h10, 16'h1234); wr(8'h11, 16'hFFFF);
    wr(8'h12, 16'h00A0); wr(8'h13, 16'h00F0);
    wr(8'h14, 16'h0000); wr(8'h15, 16'h0000);
    wr(8'h16, 16'hFFFF); wr(8'h17, 16'h8000);
    wr(8'h20, 16'h0010); wr(8'h21, 16'h0020);
    wr(8'h22, 16'h1234); wr(8'h23, 16'h1234);
    wr(8'h30, 16'h0001); wr(8'h31, 16'h0002); wr(8'h32, 16'h0100);
    // R2 readback and unmapped
    rd_chk(8'h13, 16'h00F0, "R2");
    rd_chk(8'h22, 16'h1234, "R2");
    rd_chk(8'h31, 16'h0002, "R2");
    rd_chk(8'h32, 16'h0100, "R2");
    rd_chk(8'h7F, 16'h0000, "R2");
    // vector table, first entry is the first sample after reset (R7)
    for (int k = 0; k < NV; k++) begin
      send(VEC[k][39:24], VEC[k][23:8]);
      chk(m_valid == 1, "R9", "m_valid after accept", m_valid, 1);
      chk(m_pat == VEC[k][7:4], "R3", "pattern flags", m_pat, VEC[k][7:4]);
      chk(m_in_range == VEC[k][3:2], "R4", "in-range flags", m_in_range, VEC[k][3:2]);
      chk(m_out_range == ~VEC[k][3:2], "R5", "out-of-range flags", m_out_range, ~VEC[k][3:2]);
      chk(m_edge == VEC[k][1], (k == 0) ? "R7" : "R6", "edge flag", m_edge, VEC[k][1]);
      chk(m_glitch == VEC[k][0], "R8", "glitch flag", m_glitch, VEC[k][0]);
    end
    @(negedge clk); #1;
    chk(m_valid == 0, "R9", "m_valid drops after drain", m_valid, 0);
    // R10 back-pressure
    m_ready = 0;
    @(negedge clk); s_valid = 1; s_sample = 16'h1234; s_glitch = '0;
    @(negedge clk); s_sample = 16'h0000; #1;
    chk(s_ready == 0, "R10", "s_ready stalled", s_ready, 0);
    chk(m_pat == 4'b0101, "R10", "flags of first sample", m_pat, 4'b0101);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk(m_valid == 1 && m_pat == 4'b0101 && m_in_range == 2'b10, "R10", "held flags",
          {m_valid, m_pat, m_in_range}, {1'b1, 4'b0101, 2'b10});
    end
    m_ready = 1; #1;
    chk(s_ready == 1, "R10", "s_ready on drain", s_ready, 1);
    @(negedge clk); s_valid = 0; #1;
    chk(m_pat == 4'b0100 && m_in_range == 2'b00, "R10", "stalled sample delivered",
        {m_pat, m_in_range}, {4'b0100, 2'b00});
    // second reset
    @(negedge clk); rst_n = 0;
    @(negedge clk); #1;
    chk(m_valid == 0, "R11", "m_valid after reset", m_valid, 0);
    rst_n = 1;
    rd_chk(8'h30, 16'h0000, "R11");
    rd_chk(8'h00, 16'h0000, "R11");
    // R7 first sample cannot fire an edge even against the cleared history
    wr(8'h30, 16'h0001);
    send(16'h0001, 16'h0000);
    chk(m_edge == 0, "R7", "no edge on first sample", m_edge, 0);
    send(16'h0000, 16'h0000);
    chk(m_edge == 0, "R6", "fall not enabled", m_edge, 0);
    send(16'h0001, 16'h0000);
    chk(m_edge == 1, "R6", "enabled rise", m_edge, 1);
    chk(m_pat == 4'b1111, "R3", "zero masks match all", m_pat, 4'b1111);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule